// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block runs next to a synchronous DRAM controller and handles every refresh and low-power transition for the device. It contains a refresh-interval timer that asks for a periodic auto-refresh. It also takes two level requests from the main controller, one for self-refresh and one for power-down, along with a per-bank open-row status vector. It drives the DRAM clock-enable line and a small command bus, and that bus only ever carries NOP, precharge-all or auto-refresh.

Before any refresh, the block closes open rows with a precharge-all and waits the precharge time. Each refresh command is followed by NOPs for the refresh recovery time. Self-refresh is wrapped in a full burst of refreshes on entry and another on exit, and the exit also waits out the recovery time. Power-down is entered by dropping clock enable. An output records whether rows were open at entry, which makes it an active power-down, or not, which makes it a precharge power-down.

The `busy` output tells the main scheduler when it must not issue commands. `busy` is high while a request is being serviced, while any timing window is running, while clock enable is low, and while a periodic refresh is pending. Both requests are levels: the controller holds a request high to stay in that mode and drops it to leave. All timing values are cycle-count parameters.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset, `cke` is 1, the command is NOP and `busy` is 0.
- R2: The command bus {cs_n,ras_n,cas_n,we_n} carries only these values. NOP is 0111 with `cmd_a10`=0. Precharge-all is 0010 with `cmd_a10`=1. Refresh is 0001 with `cmd_a10`=0.
- R3: If any bit of `bank_open` is set when a refresh sequence starts, a precharge-all is issued first. The next non-NOP command follows exactly T_RP cycles later and is a refresh.
- R4: After every refresh command, at least T_RFC cycles pass before the next non-NOP command. Only NOPs are driven in between, and `busy` stays high.
- R5: With banks closed and no requests, periodic refresh commands are spaced exactly T_REFI cycles apart, and `busy` is low between them.
- R6: While `sr_req` is high, the block first issues exactly BURST_LEN refreshes with `cke` high. It then issues a refresh with `cke` low, which is the self-refresh entry.
- R7: In self-refresh, `cke` stays low, the command is NOP, `busy` is high and no periodic refresh occurs, for as long as `sr_req` stays high.
- R8: When `sr_req` falls, `cke` rises and the first refresh follows exactly T_RFC cycles later. A total of BURST_LEN refreshes is issued, after which `busy` falls.
- R9: While `pd_req` is high in idle and no refresh is pending, `cke` goes low with NOP commands and `busy` high. `pd_rows_open` shows whether any bank was open at entry, and it stays stable throughout the power-down.
- R10: When `pd_req` falls during power-down, `cke` is high in the next cycle with `busy` still high, and `busy` is low one cycle after that.
- R11: A periodic refresh that falls due during power-down raises `cke`, and the refresh is issued two cycles later. If `pd_req` is still high, power-down is re-entered once the refresh recovery time has passed.
- R12: `busy` is high whenever `cke` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| pd_req | input | 1 | Level request to enter and stay in power-down |
| bank_open | input | NBANK | Per-bank open-row status from the controller |
| cke | output | 1 | DRAM clock enable |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | All-banks qualifier for precharge |
| busy | output | 1 | Scheduler must not issue commands while high |
| pd_rows_open | output | 1 | Power-down entered with rows open (active power-down) |

## Verification
The assertions check the command encoding on every cycle. They also check the refresh-recovery and precharge gaps, the NOP-only window after self-refresh exit, NOPs while clock enable stays low, `busy` while clock enable is low, and the stability of the power-down kind flag. Only the bench's scenarios can show the sequencing itself: the exact periodic spacing, the refresh counts before entry and after exit, that precharge comes first when rows are open, and that a pending refresh interrupts power-down and power-down then resumes.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_RP_WAIT,
    ST_REF,
    ST_RFC_WAIT,
    ST_SRE,
    ST_SR,
    ST_SRX,
    ST_SRX_WAIT,
    ST_PD,
    ST_PDX
  } lp_state_e;

  typedef enum logic [1:0] {
    SEQ_PERIODIC,
    SEQ_SR_PRE,
    SEQ_SR_POST
  } seq_kind_e;

  // {cs_n, ras_n, cas_n, we_n, a10}
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } dram_cmd_t;

  localparam dram_cmd_t CMD_NOP  = 5'b0111_0;
  localparam dram_cmd_t CMD_PREA = 5'b0010_1;
  localparam dram_cmd_t CMD_REF  = 5'b0001_0;

endpackage

// File: rtl/lp_refi_timer.sv
module lp_refi_timer #(
  parameter int T_REFI = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic hold,
  output logic due
);
  localparam int CW = $clog2(T_REFI + 1);

  logic [CW-1:0] cnt;

  // cnt holds the number of cycles since the last restart; due is raised so
  // that the sequencer can issue the next refresh exactly T_REFI cycles later.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= CW'(1);
      due <= 1'b0;
    end else if (restart || hold) begin
      cnt <= CW'(1);
      due <= 1'b0;
    end else if (!due) begin
      cnt <= cnt + CW'(1);
      if (cnt == CW'(T_REFI - 2)) due <= 1'b1;
    end
  end
endmodule

// File: rtl/lp_gap_timer.sv
module lp_gap_timer #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          expire
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - GW'(1);
  end

  // last waiting cycle of the window
  assign expire = (cnt == GW'(1));
endmodule

// File: rtl/lp_burst_ctr.sv
module lp_burst_ctr #(
  parameter int BURST_LEN = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_full,
  input  logic load_one,
  input  logic dec,
  output logic zero
);
  localparam int BW = $clog2(BURST_LEN + 1);

  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (load_full)            cnt <= BW'(BURST_LEN);
    else if (load_one)             cnt <= BW'(1);
    else if (dec && cnt != '0)     cnt <= cnt - BW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int NBANK     = 4,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 9,
  parameter int T_REFI    = 1560,
  parameter int BURST_LEN = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_req,
  input  logic             pd_req,
  input  logic [NBANK-1:0] bank_open,
  output logic             cke,
  output logic             cmd_cs_n,
  output logic             cmd_ras_n,
  output logic             cmd_cas_n,
  output logic             cmd_we_n,
  output logic             cmd_a10,
  output logic             busy,
  output logic             pd_rows_open
);
  localparam int GMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int GW   = $clog2(GMAX + 1);

  lp_state_e state, nxt_state;
  seq_kind_e kind,  nxt_kind;

  logic          any_open;
  logic          due;
  logic          gap_load, gap_expire;
  logic [GW-1:0] gap_val;
  logic          burst_full, burst_one, burst_dec, burst_zero;
  logic          pd_flag_load;
  dram_cmd_t     cmd;

  assign any_open = |bank_open;

  lp_refi_timer #(.T_REFI(T_REFI)) u_refi (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state == ST_REF || state == ST_SRE),
    .hold    (state == ST_SR),
    .due     (due)
  );

  lp_gap_timer #(.GW(GW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .expire   (gap_expire)
  );

  lp_burst_ctr #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_full (burst_full),
    .load_one  (burst_one),
    .dec       (burst_dec),
    .zero      (burst_zero)
  );

  always_comb begin
    nxt_state    = state;
    nxt_kind     = kind;
    gap_load     = 1'b0;
    gap_val      = '0;
    burst_full   = 1'b0;
    burst_one    = 1'b0;
    burst_dec    = 1'b0;
    pd_flag_load = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (due) begin
          nxt_kind  = SEQ_PERIODIC;
          burst_one = 1'b1;
          nxt_state = any_open ? ST_PRE : ST_REF;
        end else if (sr_req) begin
          nxt_kind   = SEQ_SR_PRE;
          burst_full = 1'b1;
          nxt_state  = any_open ? ST_PRE : ST_REF;
        end else if (pd_req) begin
          pd_flag_load = 1'b1;
          nxt_state    = ST_PD;
        end
      end
      ST_PRE: begin
        gap_load  = 1'b1;
        gap_val   = GW'(T_RP - 1);
        nxt_state = ST_RP_WAIT;
      end
      ST_RP_WAIT: begin
        if (gap_expire) nxt_state = ST_REF;
      end
      ST_REF: begin
        gap_load  = 1'b1;
        gap_val   = GW'(T_RFC - 1);
        burst_dec = 1'b1;
        nxt_state = ST_RFC_WAIT;
      end
      ST_RFC_WAIT: begin
        if (gap_expire) begin
          if (!burst_zero)              nxt_state = ST_REF;
          else if (kind == SEQ_SR_PRE)  nxt_state = ST_SRE;
          else                          nxt_state = ST_IDLE;
        end
      end
      ST_SRE: nxt_state = ST_SR;
      ST_SR: begin
        if (!sr_req) nxt_state = ST_SRX;
      end
      ST_SRX: begin
        gap_load   = 1'b1;
        gap_val    = GW'(T_RFC - 1);
        burst_full = 1'b1;
        nxt_kind   = SEQ_SR_POST;
        nxt_state  = ST_SRX_WAIT;
      end
      ST_SRX_WAIT: begin
        if (gap_expire) nxt_state = ST_REF;
      end
      ST_PD: begin
        if (due || !pd_req) nxt_state = ST_PDX;
      end
      ST_PDX:  nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      kind         <= SEQ_PERIODIC;
      pd_rows_open <= 1'b0;
    end else begin
      state <= nxt_state;
      kind  <= nxt_kind;
      if (pd_flag_load) pd_rows_open <= any_open;
    end
  end

  always_comb begin
    unique case (state)
      ST_PRE:         cmd = CMD_PREA;
      ST_REF, ST_SRE: cmd = CMD_REF;
      default:        cmd = CMD_NOP;
    endcase
  end

  assign cke       = !(state == ST_SRE || state == ST_SR || state == ST_PD);
  assign cmd_cs_n  = cmd.cs_n;
  assign cmd_ras_n = cmd.ras_n;
  assign cmd_cas_n = cmd.cas_n;
  assign cmd_we_n  = cmd.we_n;
  assign cmd_a10   = cmd.a10;
  assign busy      = (state != ST_IDLE) || due;

endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk #(
  parameter int T_RP  = 3,
  parameter int T_RFC = 9
) (
  input logic clk,
  input logic rst_n,
  input logic cke,
  input logic cmd_cs_n,
  input logic cmd_ras_n,
  input logic cmd_cas_n,
  input logic cmd_we_n,
  input logic cmd_a10,
  input logic busy,
  input logic pd_rows_open
);
  logic [4:0]  c5;
  logic        is_nop, is_pre, is_ref;
  logic [15:0] since_ref, since_pre, since_srx;
  logic        was_sr;

  assign c5     = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10};
  assign is_nop = (c5 == 5'b0111_0);
  assign is_pre = (c5 == 5'b0010_1);
  assign is_ref = (c5 == 5'b0001_0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref <= 16'hFFFF;
      since_pre <= 16'hFFFF;
      since_srx <= 16'hFFFF;
      was_sr    <= 1'b0;
    end else begin
      if (is_ref)                    since_ref <= 16'd1;
      else if (since_ref != 16'hFFFF) since_ref <= since_ref + 16'd1;
      if (is_pre)                    since_pre <= 16'd1;
      else if (since_pre != 16'hFFFF) since_pre <= since_pre + 16'd1;
      if (cke && was_sr)             since_srx <= 16'd1;
      else if (since_srx != 16'hFFFF) since_srx <= since_srx + 16'd1;
      if (!cke && is_ref)            was_sr <= 1'b1;
      else if (cke)                  was_sr <= 1'b0;
    end
  end

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_pre || is_ref); // R2
  AST_RFC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> since_ref >= 16'(T_RFC)); // R4
  AST_RP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> since_pre >= 16'(T_RP)); // R3
  AST_SRX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> since_srx >= 16'(T_RFC)); // R8
  AST_LOWPWR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> is_nop); // R7
  AST_LOWPWR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy); // R12
  AST_PD_KIND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> $stable(pd_rows_open)); // R9

endmodule

bind sdram_lp_seq sdram_lp_seq_chk #(.T_RP(T_RP), .T_RFC(T_RFC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cke          (cke),
  .cmd_cs_n     (cmd_cs_n),
  .cmd_ras_n    (cmd_ras_n),
  .cmd_cas_n    (cmd_cas_n),
  .cmd_we_n     (cmd_we_n),
  .cmd_a10      (cmd_a10),
  .busy         (busy),
  .pd_rows_open (pd_rows_open)
);

// File: tb/sdram_lp_seq_tb.sv
module sdram_lp_seq_tb;
  localparam int NB    = 4;
  localparam int TRP   = 3;
  localparam int TRFC  = 5;
  localparam int TREFI = 60;
  localparam int BL    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sr_req = 1'b0;
  logic          pd_req = 1'b0;
  logic [NB-1:0] bank_open = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, a10, busy, pd_rows_open;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int mon_err = 0;
  int last_ref = -1000;
  int last_pre = -1000;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_lp_seq #(.NBANK(NB), .T_RP(TRP), .T_RFC(TRFC), .T_REFI(TREFI),
                 .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .pd_req(pd_req),
    .bank_open(bank_open), .cke(cke), .cmd_cs_n(cs_n), .cmd_ras_n(ras_n),
    .cmd_cas_n(cas_n), .cmd_we_n(we_n), .cmd_a10(a10), .busy(busy),
    .pd_rows_open(pd_rows_open)
  );

  wire [4:0] c5     = {cs_n, ras_n, cas_n, we_n, a10};
  wire       is_nop = (c5 == 5'b0111_0);
  wire       is_pre = (c5 == 5'b0010_1);
  wire       is_ref = (c5 == 5'b0001_0);

  // independent gap monitor (R3, R4)
  always @(negedge clk) begin
    if (rst_n && !is_nop) begin
      if (cyc - last_ref < TRFC) mon_err <= mon_err + 1;
      if (cyc - last_pre < TRP)  mon_err <= mon_err + 1;
      if (is_ref) last_ref <= cyc;
      if (is_pre) last_pre <= cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle; the controller model closes all rows when it sees precharge-all
  task automatic step();
    @(negedge clk);
    if (is_pre) bank_open = '0;
  endtask

  task automatic wait_ref_cke_high(output bit found);
    found = 0;
    for (int i = 0; i < 3 * TREFI; i++) begin
      step();
      if (is_ref && cke) begin found = 1; break; end
    end
  endtask

  task automatic sync_after_ref();
    bit f;
    wait_ref_cke_high(f);
    for (int i = 0; i < 4 * TRFC && busy; i++) step();
  endtask

  task automatic t_reset();
    step();
    check(cke == 1'b1, "R1 cke", cke, 1);
    check(is_nop, "R1 cmd", c5, 5'b01110);
    check(busy == 1'b0, "R1 busy", busy, 0);
  endtask

  task automatic t_periodic();
    bit f;
    int t0, t1, bad;
    wait_ref_cke_high(f);
    t0 = cyc;
    bad = 0;
    for (int i = 1; i < TRFC; i++) begin
      step();
      if (!is_nop || !busy) bad++;
    end
    check(bad == 0, "R4 nop and busy in recovery", bad, 0);
    step();
    check(busy == 1'b0, "R5 busy low after refresh", busy, 0);
    wait_ref_cke_high(f);
    t1 = cyc;
    check(f && (t1 - t0) == TREFI, "R5 refresh spacing", t1 - t0, TREFI);
  endtask

  task automatic t_prech();
    int k;
    sync_after_ref();
    bank_open = 4'b0110;
    k = 0;
    while (is_nop && k < 3 * TREFI) begin step(); k++; end
    check(is_pre, "R2 precharge-all encoding", c5, 5'b00101);
    k = 0;
    do begin step(); k++; end while (is_nop && k < 20);
    check(is_ref, "R3 refresh follows precharge", c5, 5'b00010);
    check(k == TRP, "R3 precharge gap", k, TRP);
  endtask

  task automatic t_selfref();
    int npre, nref, k, bad;
    sync_after_ref();
    bank_open = 4'b1000;
    sr_req = 1'b1;
    npre = 0; nref = 0; k = 0;
    do begin
      step(); k++;
      if (is_pre) npre++;
      if (is_ref && cke) nref++;
    end while (cke && k < 200);
    check(npre == 1, "R3 precharge before self-refresh burst", npre, 1);
    check(nref == BL, "R6 entry burst count", nref, BL);
    check(!cke && is_ref, "R6 entry command with cke low", c5, 5'b00010);
    bad = 0;
    for (int i = 0; i < 2 * TREFI; i++) begin
      step();
      if (cke || !is_nop || !busy) bad++;
    end
    check(bad == 0, "R7 held in self-refresh", bad, 0);
    sr_req = 1'b0;
    step();
    check(cke == 1'b1 && is_nop, "R8 cke rises on exit", cke, 1);
    k = 0;
    do begin step(); k++; end while (is_nop && k < 20);
    check(is_ref && k == TRFC, "R8 exit recovery gap", k, TRFC);
    nref = 1; k = 0;
    while (busy && k < 200) begin
      step(); k++;
      if (is_ref) nref++;
    end
    check(nref == BL, "R8 exit burst count", nref, BL);
  endtask

  task automatic t_pd(input logic [NB-1:0] rows);
    int k;
    sync_after_ref();
    bank_open = rows;
    pd_req = 1'b1;
    k = 0;
    do begin step(); k++; end while (cke && k < 10);
    check(!cke && busy, "R9 power-down entry", {cke, busy}, 2'b01);
    check(pd_rows_open == (rows != '0), "R9 power-down kind",
          pd_rows_open, int'(rows != '0));
    for (int i = 0; i < 5; i++) step();
    check(!cke && is_nop, "R9 stays low", cke, 0);
    pd_req = 1'b0;
    step();
    check(cke && busy, "R10 exit cycle", {cke, busy}, 2'b11);
    step();
    check(!busy, "R10 busy released", busy, 0);
    bank_open = '0;
  endtask

  task automatic t_pd_refresh();
    int k;
    sync_after_ref();
    pd_req = 1'b1;
    k = 0;
    do begin step(); k++; end while (cke && k < 10);
    k = 0;
    do begin step(); k++; end while (!cke && k < 3 * TREFI);
    check(cke == 1'b1, "R11 refresh wakes power-down", cke, 1);
    k = 0;
    do begin step(); k++; end while (is_nop && k < 10);
    check(is_ref && k == 2, "R11 refresh after wake", k, 2);
    k = 0;
    do begin step(); k++; end while (cke && k < 3 * TRFC);
    check(!cke && k == TRFC + 1, "R11 power-down resumes", k, TRFC + 1);
    pd_req = 1'b0;
    for (int i = 0; i < 4; i++) step();
    check(cke && !busy, "R12 idle after leaving power-down", busy, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_periodic();
    t_prech();
    t_selfref();
    t_pd(4'b0011);
    t_pd(4'b0000);
    t_pd_refresh();
    step();
    check(mon_err == 0, "R4 gap monitor", mon_err, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule